// File: doc/BRIEF.md
# Register Alias Table With Branch Checkpoints

This block holds the rename map of an out-of-order core: for every architectural register it records the physical register that currently holds its newest value. Alongside the map it keeps one ready bit for every physical register. A ready bit of 1 means the value has been produced and may be read. Source lookups return both the mapping and the ready bit of the mapped physical register. Destination renames install a new mapping and mark the new physical register as not ready.

When a branch is renamed, the surrounding logic saves the live map into one of a small number of checkpoint slots. If the branch turns out to be mispredicted, the chosen slot is copied back into the live map in a single cycle. Ready bits live on the physical side, so a restore leaves them alone. Instructions squashed by the misprediction would never write back. Their destination physical registers are therefore marked ready through a separate port, so that no consumer waits on them forever. There is one register bank. The free list, the reorder buffer and branch resolution are outside the block.

Top module: `rat_ckpt_top`

## Requirements
- R1: During and after reset, architectural register i maps to physical register i, every checkpoint slot holds that identity map, and every physical register reads as ready (ready = 1 means available).
- R2: A rename (ren_valid, ren_arch, ren_phys) with ren_arch not 0 and no restore in the same cycle is visible on the lookup ports from the next cycle on. Architectural register 0 always looks up physical 0, which is ready, and renames of it are ignored.
- R3: A lookup in the same cycle as a rename or restore returns the mapping and ready bit from before that cycle's edge.
- R4: An accepted rename clears the ready bit of ren_phys, seen from the next cycle.
- R5: A writeback (wb_valid, wb_phys) sets that physical register's ready bit from the next cycle, and wins over a same-cycle rename clear of the same register.
- R6: The squash port (squash_valid, squash_phys) sets that physical register's ready bit from the next cycle, with the same priority over a rename clear as R5.
- R7: Ready bits belong to physical registers: a restore changes the map but no ready bit.
- R8: A snapshot (snap_valid, snap_slot) stores into slot snap_slot the live map as it stands after that cycle's rename or restore.
- R9: A restore (restore_valid, restore_slot) replaces the whole live map with slot restore_slot in one cycle. A rename in the same cycle is dropped, both in the map and in the ready bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lu_arch | input | NUM_LOOKUP x ARCH_W | Architectural registers to look up |
| lu_phys | output | NUM_LOOKUP x PHYS_W | Mapped physical registers |
| lu_ready | output | NUM_LOOKUP | Ready bit of each mapped physical register |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | ARCH_W | Destination architectural register |
| ren_phys | input | PHYS_W | Newly allocated physical register |
| wb_valid | input | 1 | Writeback strobe |
| wb_phys | input | PHYS_W | Physical register written back |
| snap_valid | input | 1 | Save the live map |
| snap_slot | input | SLOT_W | Checkpoint slot to write |
| restore_valid | input | 1 | Restore the live map |
| restore_slot | input | SLOT_W | Checkpoint slot to read |
| squash_valid | input | 1 | Mark a squashed destination ready |
| squash_phys | input | PHYS_W | Physical register of the squashed destination |

## Verification
A wrong map entry shows on the lookup ports the first time the affected architectural register is looked up after the faulty edge. A wrong checkpoint stays hidden until that slot is restored and an entry from it is read. A ready bit that is wrong or inverted appears on the first lookup that maps to that physical register. A ready bit that stays clear shows up as a register that never becomes ready after its writeback or squash. The bench looks up random registers on both ports every cycle and compares them against a map model over long mixed sequences, so a fault is reported within a few cycles of the first read that touches it.

// File: rtl/rat_pkg.sv
package rat_pkg;

    localparam int DEF_NUM_ARCH   = 32;
    localparam int DEF_NUM_PHYS   = 64;
    localparam int DEF_NUM_CKPT   = 4;
    localparam int DEF_NUM_LOOKUP = 2;

    // What the live map does at the coming edge.
    typedef enum logic [1:0] {
        MAP_HOLD    = 2'd0,
        MAP_RENAME  = 2'd1,
        MAP_RESTORE = 2'd2
    } map_op_e;

    // Select the map operation: restore wins over rename, renames of r0 are dropped.
    function automatic map_op_e pick_map_op(input logic restore, input logic rename,
                                            input logic arch_is_zero);
        if (restore)
            return MAP_RESTORE;
        else if (rename && !arch_is_zero)
            return MAP_RENAME;
        else
            return MAP_HOLD;
    endfunction

endpackage

// File: rtl/rat_map_store.sv
module rat_map_store
    import rat_pkg::*;
#(
    parameter int NUM_ARCH   = DEF_NUM_ARCH,
    parameter int NUM_PHYS   = DEF_NUM_PHYS,
    parameter int NUM_CKPT   = DEF_NUM_CKPT,
    parameter int NUM_LOOKUP = DEF_NUM_LOOKUP,
    localparam int ARCH_W    = $clog2(NUM_ARCH),
    localparam int PHYS_W    = $clog2(NUM_PHYS),
    localparam int SLOT_W    = $clog2(NUM_CKPT)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  map_op_e                            op,
    input  logic [ARCH_W-1:0]                  ren_arch,
    input  logic [PHYS_W-1:0]                  ren_phys,
    input  logic [SLOT_W-1:0]                  restore_slot,
    input  logic                               snap_valid,
    input  logic [SLOT_W-1:0]                  snap_slot,
    input  logic [NUM_LOOKUP-1:0][ARCH_W-1:0]  rd_arch,
    output logic [NUM_LOOKUP-1:0][PHYS_W-1:0]  rd_phys
);

    logic [PHYS_W-1:0] live      [NUM_ARCH];
    logic [PHYS_W-1:0] next_live [NUM_ARCH];
    logic [PHYS_W-1:0] ckpt      [NUM_CKPT][NUM_ARCH];

    always_comb begin
        next_live = live;
        case (op)
            MAP_RENAME:  next_live[ren_arch] = ren_phys;
            MAP_RESTORE: next_live = ckpt[restore_slot];
            default:     next_live = live;
        endcase
        next_live[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < NUM_ARCH; a++) begin
                live[a] <= PHYS_W'(a);
                for (int s = 0; s < NUM_CKPT; s++)
                    ckpt[s][a] <= PHYS_W'(a);
            end
        end else begin
            live <= next_live;
            if (snap_valid)
                ckpt[snap_slot] <= next_live;
        end
    end

    // Lookups read the state before this cycle's edge.
    for (genvar g = 0; g < NUM_LOOKUP; g++) begin : g_read
        assign rd_phys[g] = live[rd_arch[g]];
    end

endmodule

// File: rtl/rat_ready_bits.sv
module rat_ready_bits
    import rat_pkg::*;
#(
    parameter int NUM_PHYS   = DEF_NUM_PHYS,
    parameter int NUM_LOOKUP = DEF_NUM_LOOKUP,
    localparam int PHYS_W    = $clog2(NUM_PHYS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               clr_en,
    input  logic [PHYS_W-1:0]                  clr_phys,
    input  logic                               wb_en,
    input  logic [PHYS_W-1:0]                  wb_phys,
    input  logic                               sq_en,
    input  logic [PHYS_W-1:0]                  sq_phys,
    input  logic [NUM_LOOKUP-1:0][PHYS_W-1:0]  rd_phys,
    output logic [NUM_LOOKUP-1:0]              rd_ready
);

    logic [NUM_PHYS-1:0] ready_q;
    logic [NUM_PHYS-1:0] ready_d;

    // Clear first, then the two set sources, so a set wins over a clear.
    always_comb begin
        ready_d = ready_q;
        if (clr_en)
            ready_d[clr_phys] = 1'b0;
        if (wb_en)
            ready_d[wb_phys] = 1'b1;
        if (sq_en)
            ready_d[sq_phys] = 1'b1;
        ready_d[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ready_q <= '1;
        else
            ready_q <= ready_d;
    end

    for (genvar g = 0; g < NUM_LOOKUP; g++) begin : g_read
        assign rd_ready[g] = ready_q[rd_phys[g]];
    end

endmodule

// File: rtl/rat_ckpt_top.sv
module rat_ckpt_top
    import rat_pkg::*;
#(
    parameter int NUM_ARCH   = DEF_NUM_ARCH,
    parameter int NUM_PHYS   = DEF_NUM_PHYS,
    parameter int NUM_CKPT   = DEF_NUM_CKPT,
    parameter int NUM_LOOKUP = DEF_NUM_LOOKUP,
    localparam int ARCH_W    = $clog2(NUM_ARCH),
    localparam int PHYS_W    = $clog2(NUM_PHYS),
    localparam int SLOT_W    = $clog2(NUM_CKPT)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_LOOKUP-1:0][ARCH_W-1:0]  lu_arch,
    output logic [NUM_LOOKUP-1:0][PHYS_W-1:0]  lu_phys,
    output logic [NUM_LOOKUP-1:0]              lu_ready,
    input  logic                               ren_valid,
    input  logic [ARCH_W-1:0]                  ren_arch,
    input  logic [PHYS_W-1:0]                  ren_phys,
    input  logic                               wb_valid,
    input  logic [PHYS_W-1:0]                  wb_phys,
    input  logic                               snap_valid,
    input  logic [SLOT_W-1:0]                  snap_slot,
    input  logic                               restore_valid,
    input  logic [SLOT_W-1:0]                  restore_slot,
    input  logic                               squash_valid,
    input  logic [PHYS_W-1:0]                  squash_phys
);

    map_op_e op;
    logic    rename_taken;

    assign op           = pick_map_op(restore_valid, ren_valid, ren_arch == '0);
    assign rename_taken = (op == MAP_RENAME);

    rat_map_store #(
        .NUM_ARCH   (NUM_ARCH),
        .NUM_PHYS   (NUM_PHYS),
        .NUM_CKPT   (NUM_CKPT),
        .NUM_LOOKUP (NUM_LOOKUP)
    ) u_map (
        .clk          (clk),
        .rst          (rst),
        .op           (op),
        .ren_arch     (ren_arch),
        .ren_phys     (ren_phys),
        .restore_slot (restore_slot),
        .snap_valid   (snap_valid),
        .snap_slot    (snap_slot),
        .rd_arch      (lu_arch),
        .rd_phys      (lu_phys)
    );

    rat_ready_bits #(
        .NUM_PHYS   (NUM_PHYS),
        .NUM_LOOKUP (NUM_LOOKUP)
    ) u_ready (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (rename_taken),
        .clr_phys (ren_phys),
        .wb_en    (wb_valid),
        .wb_phys  (wb_phys),
        .sq_en    (squash_valid),
        .sq_phys  (squash_phys),
        .rd_phys  (lu_phys),
        .rd_ready (lu_ready)
    );

endmodule

// File: rtl/rat_ckpt_chk.sv
module rat_ckpt_chk #(
    parameter int NUM_LOOKUP = 2,
    parameter int ARCH_W     = 5,
    parameter int PHYS_W     = 6
) (
    input logic                               clk,
    input logic                               rst,
    input logic [NUM_LOOKUP-1:0][ARCH_W-1:0]  lu_arch,
    input logic [NUM_LOOKUP-1:0][PHYS_W-1:0]  lu_phys,
    input logic [NUM_LOOKUP-1:0]              lu_ready,
    input logic                               ren_valid,
    input logic [ARCH_W-1:0]                  ren_arch,
    input logic [PHYS_W-1:0]                  ren_phys,
    input logic                               wb_valid,
    input logic [PHYS_W-1:0]                  wb_phys,
    input logic                               restore_valid,
    input logic                               squash_valid,
    input logic [PHYS_W-1:0]                  squash_phys
);

    p_arch0_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        (lu_arch[0] == '0) |-> (lu_phys[0] == '0 && lu_ready[0]));

    p_rename_visible_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(ren_valid && ren_arch != '0 && !restore_valid && !rst)
         && lu_arch[0] == $past(ren_arch))
        |-> (lu_phys[0] == $past(ren_phys)));

    p_ready_cleared_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(ren_valid && ren_arch != '0 && !restore_valid && !rst && ren_phys != '0
               && !(wb_valid && wb_phys == ren_phys)
               && !(squash_valid && squash_phys == ren_phys))
         && lu_phys[0] == $past(ren_phys))
        |-> !lu_ready[0]);

    p_wb_ready_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(wb_valid && !rst) && lu_phys[0] == $past(wb_phys)) |-> lu_ready[0]);

    p_squash_ready_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(squash_valid && !rst) && lu_phys[0] == $past(squash_phys)) |-> lu_ready[0]);

endmodule

bind rat_ckpt_top rat_ckpt_chk #(
    .NUM_LOOKUP (NUM_LOOKUP),
    .ARCH_W     (ARCH_W),
    .PHYS_W     (PHYS_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lu_arch       (lu_arch),
    .lu_phys       (lu_phys),
    .lu_ready      (lu_ready),
    .ren_valid     (ren_valid),
    .ren_arch      (ren_arch),
    .ren_phys      (ren_phys),
    .wb_valid      (wb_valid),
    .wb_phys       (wb_phys),
    .restore_valid (restore_valid),
    .squash_valid  (squash_valid),
    .squash_phys   (squash_phys)
);

// File: tb/sim_rat_ckpt_top.sv
module sim_rat_ckpt_top;

    localparam int NA = 32;
    localparam int NP = 64;
    localparam int NC = 4;
    localparam int NL = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NL-1:0][4:0]   lu_arch = '0;
    logic [NL-1:0][5:0]   lu_phys;
    logic [NL-1:0]        lu_ready;
    logic                 ren_valid = 1'b0;
    logic [4:0]           ren_arch = '0;
    logic [5:0]           ren_phys = '0;
    logic                 wb_valid = 1'b0;
    logic [5:0]           wb_phys = '0;
    logic                 snap_valid = 1'b0;
    logic [1:0]           snap_slot = '0;
    logic                 restore_valid = 1'b0;
    logic [1:0]           restore_slot = '0;
    logic                 squash_valid = 1'b0;
    logic [5:0]           squash_phys = '0;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    string tag_map = "R1";
    string tag_rdy = "R1";

    int ref_map [NA];
    int ref_ck  [NC][NA];
    bit ref_rdy [NP];

    always #4 clk = ~clk;

    rat_ckpt_top u0 (
        .clk(clk), .rst(rst), .lu_arch(lu_arch), .lu_phys(lu_phys), .lu_ready(lu_ready),
        .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_phys(ren_phys),
        .wb_valid(wb_valid), .wb_phys(wb_phys),
        .snap_valid(snap_valid), .snap_slot(snap_slot),
        .restore_valid(restore_valid), .restore_slot(restore_slot),
        .squash_valid(squash_valid), .squash_phys(squash_phys)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        ren_valid = 0; wb_valid = 0; snap_valid = 0; restore_valid = 0; squash_valid = 0;
    endtask

    // Reference update derived from the requirements.
    task automatic model_edge();
        int nm [NA];
        nm = ref_map;
        if (restore_valid)
            nm = ref_ck[restore_slot];
        else if (ren_valid && ren_arch != 0)
            nm[ren_arch] = ren_phys;
        if (snap_valid)
            ref_ck[snap_slot] = nm;
        ref_map = nm;
        if (!restore_valid && ren_valid && ren_arch != 0)
            ref_rdy[ren_phys] = 1'b0;
        if (wb_valid)
            ref_rdy[wb_phys] = 1'b1;
        if (squash_valid)
            ref_rdy[squash_phys] = 1'b1;
        ref_rdy[0] = 1'b1;
    endtask

    // Called just after a falling edge with inputs set; compares, then advances one cycle.
    task automatic tick();
        #1;
        for (int g = 0; g < NL; g++) begin
            chk(tag_map, int'(lu_phys[g]), ref_map[lu_arch[g]]);
            chk(tag_rdy, int'(lu_ready[g]), int'(ref_rdy[ref_map[lu_arch[g]]]));
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic look(input int a0, input int a1, input string tm, input string tr);
        idle();
        lu_arch[0] = 5'(a0);
        lu_arch[1] = 5'(a1);
        tag_map = tm;
        tag_rdy = tr;
        tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NA; a++) begin
            ref_map[a] = a;
            for (int s = 0; s < NC; s++) ref_ck[s][a] = a;
        end
        for (int p = 0; p < NP; p++) ref_rdy[p] = 1'b1;

        // R1: outputs while reset is held, then sweep all registers after release
        repeat (3) @(negedge clk);
        tag_map = "R1 in reset"; tag_rdy = "R1 in reset";
        lu_arch[0] = 5'd7; lu_arch[1] = 5'd31;
        #1;
        chk("R1 in reset", int'(lu_phys[0]), 7);
        chk("R1 in reset", int'(lu_phys[1]), 31);
        chk("R1 in reset", int'(lu_ready), 3);
        rst = 1'b0;
        for (int a = 0; a < NA; a += 2)
            look(a, a + 1, "R1 identity map", "R1 ready after reset");

        // R2/R3/R4: rename 5 -> 40; same-cycle lookup sees old mapping
        idle(); lu_arch[0] = 5; lu_arch[1] = 0;
        ren_valid = 1; ren_arch = 5; ren_phys = 40;
        tag_map = "R3 old mapping"; tag_rdy = "R3 old ready";
        tick();
        look(5, 0, "R2 new mapping", "R4 ready cleared");

        // R2: rename of arch 0 ignored
        idle(); ren_valid = 1; ren_arch = 0; ren_phys = 33;
        lu_arch[0] = 0; lu_arch[1] = 5; tag_map = "R2 arch0"; tag_rdy = "R2 arch0";
        tick();
        look(0, 1, "R2 arch0 fixed", "R2 arch0 ready");

        // R5: writeback sets ready; same-cycle writeback wins over clear
        idle(); wb_valid = 1; wb_phys = 40; lu_arch[0] = 5; tag_map = "R5"; tag_rdy = "R5";
        tick();
        look(5, 1, "R5 map", "R5 wb ready");
        idle(); ren_valid = 1; ren_arch = 6; ren_phys = 41; wb_valid = 1; wb_phys = 41;
        tick();
        look(6, 5, "R5 map", "R5 wb beats clear");

        // R6: squash marks ready; same-cycle squash wins over clear
        idle(); ren_valid = 1; ren_arch = 7; ren_phys = 42;
        tick();
        look(7, 6, "R6 map", "R6 not ready before squash");
        idle(); squash_valid = 1; squash_phys = 42; lu_arch[0] = 7;
        tick();
        look(7, 6, "R6 map", "R6 squash ready");
        idle(); ren_valid = 1; ren_arch = 8; ren_phys = 43; squash_valid = 1; squash_phys = 43;
        tick();
        look(8, 7, "R6 map", "R6 squash beats clear");

        // R8/R9: snapshot includes same-cycle rename; restore returns to it
        idle(); ren_valid = 1; ren_arch = 9; ren_phys = 44; snap_valid = 1; snap_slot = 1;
        tick();
        idle(); ren_valid = 1; ren_arch = 9; ren_phys = 45;
        tick();
        idle(); ren_valid = 1; ren_arch = 5; ren_phys = 50;
        tick();
        look(9, 5, "R8 before restore", "R8 ready");
        idle(); restore_valid = 1; restore_slot = 1; ren_valid = 1; ren_arch = 10; ren_phys = 46;
        lu_arch[0] = 9; lu_arch[1] = 10; tag_map = "R3 before restore edge"; tag_rdy = "R3";
        tick();
        look(9, 5, "R8 restored snapshot", "R7 ready kept");
        look(10, 1, "R9 rename dropped", "R9 ready untouched");

        // R7: restore does not rewrite ready bits
        idle(); ren_valid = 1; ren_arch = 16; ren_phys = 49; snap_valid = 1; snap_slot = 2;
        tick();
        idle(); ren_valid = 1; ren_arch = 16; ren_phys = 51;
        tick();
        idle(); restore_valid = 1; restore_slot = 2;
        tick();
        look(16, 0, "R7 map after restore", "R7 still not ready");
        idle(); wb_valid = 1; wb_phys = 49; tick();
        idle(); restore_valid = 1; restore_slot = 2; tick();
        look(16, 0, "R7 map", "R7 ready survives restore");

        // R9: snapshot in the same cycle as restore captures restored map
        idle(); restore_valid = 1; restore_slot = 0; snap_valid = 1; snap_slot = 3; tick();
        idle(); ren_valid = 1; ren_arch = 9; ren_phys = 60; tick();
        idle(); restore_valid = 1; restore_slot = 3; tick();
        look(9, 16, "R9 snapshot of restored map", "R9 ready");

        // Mixed random sequence against the model
        for (int n = 0; n < 4000; n++) begin
            idle();
            lu_arch[0] = 5'($urandom_range(0, NA - 1));
            lu_arch[1] = 5'($urandom_range(0, NA - 1));
            ren_valid  = ($urandom_range(0, 9) < 6);
            ren_arch   = 5'($urandom_range(0, NA - 1));
            ren_phys   = 6'($urandom_range(1, NP - 1));
            wb_valid   = ($urandom_range(0, 9) < 4);
            wb_phys    = 6'($urandom_range(0, NP - 1));
            squash_valid = ($urandom_range(0, 9) < 1);
            squash_phys  = 6'($urandom_range(0, NP - 1));
            snap_valid   = ($urandom_range(0, 9) < 1);
            snap_slot    = 2'($urandom_range(0, NC - 1));
            restore_valid = ($urandom_range(0, 19) < 1);
            restore_slot  = 2'($urandom_range(0, NC - 1));
            tag_map = ren_valid ? "R3 random" : "R2 random";
            tag_rdy = "R4 random";
            tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule